// File: doc/BRIEF.md
# Elapsed Time Encoder with Compressed 8-bit Code

This block measures how long an event readout lasts and gives the result as an 8-bit pseudo-floating code that fits a narrow trailer field. The time base comes from a one-cycle tick-enable input; each tick stands for one 0.41 µs unit. A start pulse clears the measurement and starts it. A stop pulse freezes the code until the next start.

The code holds one exponent bit in its MSB and a 7-bit mantissa below it. The time it represents is mantissa × 16^exponent × 0.41 µs. With exponent 0 the mantissa counts single ticks. When the mantissa would pass its top value, the code moves to exponent 1 with mantissa 8, so the value stays continuous. From then on a 4-bit prescaler lets the mantissa step once every 16 ticks. The code then saturates at its largest value.

Top module: `pft_elapsed_encoder`

## Requirements
- R1: While reset is asserted, and after its release, code_o is 0x00.
- R2: With exponent bit 7 at 0, every tick counted after a start raises code_o by one. After N counted ticks, for N from 0 to 127, code_o equals N.
- R3: The 128th counted tick after a start sets code_o to 0x88: bit 7 is 1 and the mantissa in bits 6:0 is 8.
- R4: With bit 7 at 1, the mantissa in bits 6:0 rises once every 16 counted ticks. After N counted ticks, for N from 128 to 2031, code_o equals 0x80 | (N / 16), with N / 16 rounded down.
- R5: Once N reaches 2032, code_o is 0xFF. It stays 0xFF for any further ticks.
- R6: In the cycle after a start pulse, code_o is 0x00. A tick in the same cycle as start is not counted.
- R7: A stop pulse (without start) ends counting. Neither a tick in the stop cycle nor any later tick changes code_o until the next start.
- R8: When start and stop are high in the same cycle, start wins. The code clears and the following ticks are counted.
- R9: Ticks that arrive after reset and before the first start leave code_o at 0x00.
- R10: A cycle with tick low and no start leaves code_o unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Clears the measurement and starts counting |
| stop_i | input | 1 | Freezes the code until the next start |
| tick_i | input | 1 | One-cycle enable marking one time-base unit |
| code_o | output | 8 | Bit 7 is the exponent; bits 6:0 are the mantissa |

## Verification
The assertions check on every cycle the rules that are local in time. A start clears the code, and start wins over stop. A stopped or tick-free cycle holds the code. A fine-range tick adds one. The fine-to-coarse switch loads mantissa 8. A saturated code stays put. Only the bench's scenarios can show the arithmetic over a whole run. Those scenarios cover the exact code after every tick count from 0 to past saturation, the one-in-sixteen pacing in the coarse range under both dense and sparse tick patterns, a restart partway through a run, and ticks ignored before the first start.

// File: rtl/pft_pkg.sv
package pft_pkg;
    localparam logic EXP_FINE   = 1'b0;
    localparam logic EXP_COARSE = 1'b1;

    typedef struct packed {
        logic run;
    } ctl_t;
endpackage

// File: rtl/pft_prescale.sv
module pft_prescale #(
    parameter int PRE_W = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic en_i,
    output logic wrap_o
);
    localparam logic [PRE_W-1:0] PRE_ONE = PRE_W'(1);

    typedef struct packed {
        logic [PRE_W-1:0] cnt;
    } pre_t;

    pre_t st_d, st_q;

    assign wrap_o = en_i && (st_q.cnt == '1);

    always_comb begin
        st_d = st_q;
        if (clr_i) begin
            st_d.cnt = '0;
        end else if (en_i) begin
            st_d.cnt = st_q.cnt + PRE_ONE;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R4: after a wrap the prescaler starts again from zero
    a_r4_wrap_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap_o && !clr_i) |=> (st_q.cnt == '0));
endmodule

// File: rtl/pft_code_counter.sv
module pft_code_counter
    import pft_pkg::*;
#(
    parameter int MANT_W = 7,
    parameter int PRE_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              adv_i,
    input  logic              wrap_i,
    output logic              exp_o,
    output logic [MANT_W-1:0] mant_o,
    output logic              coarse_en_o
);
    localparam logic [MANT_W-1:0] MANT_MAX = '1;
    localparam logic [MANT_W-1:0] MANT_ONE = MANT_W'(1);
    localparam logic [MANT_W-1:0] RELOAD   = MANT_W'((2 ** MANT_W) >> PRE_W);

    typedef struct packed {
        logic              expo;
        logic [MANT_W-1:0] mant;
    } cnt_t;

    cnt_t st_d, st_q;
    logic sat;

    assign sat         = (st_q.expo == EXP_COARSE) && (st_q.mant == MANT_MAX);
    assign coarse_en_o = adv_i && (st_q.expo == EXP_COARSE) && !sat;
    assign exp_o       = st_q.expo;
    assign mant_o      = st_q.mant;

    always_comb begin
        st_d = st_q;
        if (clr_i) begin
            st_d = '0;
        end else if (adv_i) begin
            if (st_q.expo == EXP_FINE) begin
                if (st_q.mant == MANT_MAX) begin
                    st_d.expo = EXP_COARSE;
                    st_d.mant = RELOAD;
                end else begin
                    st_d.mant = st_q.mant + MANT_ONE;
                end
            end else if (!sat && wrap_i) begin
                st_d.mant = st_q.mant + MANT_ONE;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    a_r2_fine_step: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_i && !clr_i && st_q.expo == EXP_FINE && st_q.mant != MANT_MAX)
        |=> (st_q.expo == EXP_FINE && st_q.mant == $past(st_q.mant) + MANT_ONE));

    a_r3_promote: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_i && !clr_i && st_q.expo == EXP_FINE && st_q.mant == MANT_MAX)
        |=> (st_q.expo == EXP_COARSE && st_q.mant == RELOAD));

    a_r5_sat_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (sat && !clr_i) |=> (st_q.expo == EXP_COARSE && st_q.mant == MANT_MAX));

    a_r4_coarse_pace: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.expo == EXP_COARSE && !clr_i && !wrap_i) |=> $stable(st_q.mant));
endmodule

// File: rtl/pft_elapsed_encoder.sv
module pft_elapsed_encoder
    import pft_pkg::*;
#(
    parameter int MANT_W = 7,
    parameter int PRE_W  = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          stop_i,
    input  logic          tick_i,
    output logic [MANT_W:0] code_o
);
    ctl_t ctl_d, ctl_q;

    logic              adv;
    logic              wrap;
    logic              coarse_en;
    logic              expo;
    logic [MANT_W-1:0] mant;

    // start takes priority; ticks in a start or stop cycle are not counted
    assign adv = ctl_q.run && tick_i && !start_i && !stop_i;

    always_comb begin
        ctl_d = ctl_q;
        if (start_i)     ctl_d.run = 1'b1;
        else if (stop_i) ctl_d.run = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    pft_prescale #(.PRE_W(PRE_W)) u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (start_i),
        .en_i   (coarse_en),
        .wrap_o (wrap)
    );

    pft_code_counter #(.MANT_W(MANT_W), .PRE_W(PRE_W)) u_cnt (
        .clk         (clk),
        .rst_n       (rst_n),
        .clr_i       (start_i),
        .adv_i       (adv),
        .wrap_i      (wrap),
        .exp_o       (expo),
        .mant_o      (mant),
        .coarse_en_o (coarse_en)
    );

    assign code_o = {expo, mant};

    a_r6_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (code_o == '0));

    a_r7_stopped_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl_q.run && !start_i) |=> $stable(code_o));

    a_r7_stop_cycle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_i && !start_i) |=> $stable(code_o));

    a_r8_start_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && stop_i) |=> ctl_q.run);

    a_r10_no_tick_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !start_i) |=> $stable(code_o));
endmodule

// File: tb/tb_pft_elapsed_encoder.sv
`timescale 1ns/1ps
module tb_pft_elapsed_encoder;
    localparam int MANT_W = 7;
    localparam int PRE_W  = 4;
    localparam int FINE_LIM = 2 ** MANT_W;                 // 128
    localparam int MAX_M    = 2 ** MANT_W - 1;             // 127
    localparam int SAT_N    = MAX_M * (2 ** PRE_W);        // 2032

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0, stop_i = 1'b0, tick_i = 1'b0;
    logic [MANT_W:0] code_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    int  m_n   = 0;
    bit  m_run = 0;

    always #4 clk = ~clk;

    pft_elapsed_encoder #(.MANT_W(MANT_W), .PRE_W(PRE_W)) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i),
        .tick_i(tick_i), .code_o(code_o)
    );

    function automatic int enc(input int n);
        if (n < FINE_LIM) return n;
        if ((n >> PRE_W) >= MAX_M) return 255;
        return 128 | (n >> PRE_W);
    endfunction

    function automatic string tag_for(input int n);
        if (n < FINE_LIM)  return "R2";
        if (n == FINE_LIM) return "R3";
        if (n < SAT_N)     return "R4";
        return "R5";
    endfunction

    task automatic check(input string tag, input int exp_v);
        checks++;
        if (code_o !== exp_v[MANT_W:0]) begin
            fails++;
            $display("FAIL %s: code_o=0x%02h expected=0x%02h (n=%0d)", tag, code_o, exp_v[7:0], m_n);
        end
    endtask

    // drive on the falling edge, sample 1 ns after the rising edge
    task automatic step(input logic s, input logic p, input logic t, input string tag);
        @(negedge clk);
        start_i = s; stop_i = p; tick_i = t;
        @(posedge clk);
        #1;
        if (s) begin m_run = 1; m_n = 0; end
        else if (p) m_run = 0;
        else if (m_run && t) m_n++;
        check(tag == "" ? tag_for(m_n) : tag, enc(m_n));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 check("R1", 0);
        @(negedge clk) rst_n = 1'b1;
        @(posedge clk); #1 check("R1", 0);

        // R9: ticks before the first start are ignored
        for (int i = 0; i < 6; i++) step(0, 0, 1, "R9");

        // R6: start with a coincident tick
        step(1, 0, 1, "R6");

        // full sweep: dense ticks through fine, switch, coarse, saturation
        for (int i = 0; i < SAT_N + 60; i++) step(0, 0, 1, "");

        // R7: stop with tick, then further ticks
        step(0, 1, 1, "R7");
        for (int i = 0; i < 20; i++) step(0, 0, 1, "R7");

        // R6: restart clears the saturated code
        step(1, 0, 0, "R6");
        // sparse ticks: tick on one cycle of every three
        for (int i = 0; i < 3 * 300; i++) begin
            if (i % 3 == 0) step(0, 0, 1, "");
            else            step(0, 0, 0, "R10");
        end

        // R6: restart mid-run
        step(1, 0, 1, "R6");
        for (int i = 0; i < 40; i++) step(0, 0, 1, "R2");

        // R8: start and stop together
        step(1, 1, 1, "R8");
        for (int i = 0; i < 12; i++) step(0, 0, 1, "R8");

        // stop in the fine range, then hold
        step(0, 1, 0, "R7");
        for (int i = 0; i < 8; i++) step(0, 0, (i % 2) == 0, "R7");

        // irregular pattern through the coarse range up to saturation
        step(1, 0, 0, "R6");
        for (int i = 0; m_n < SAT_N + 20; i++) begin
            if ((i % 5) == 1 || (i % 5) == 3) step(0, 0, 1, "");
            else                              step(0, 0, 0, "R10");
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule